// File: doc/BRIEF.md
# GPIO Bank with Edge Detection

This block is a bank of general-purpose pins, a whole multiple of 32 wide (64 by default), with a small word-addressed register port. Software sets the direction of each pin and drives its output latch through separate write-one-to-set and write-one-to-clear words, so no read-modify-write sequence is needed. It reads back the synchronised pin levels, enables detection of rising and/or falling edges per pin, and reads and acknowledges a sticky per-pin edge status. Any pending status bit raises the single interrupt line.

A 2-bit alternate-function field per pin, packed sixteen pins to a word, is driven out for the pad multiplexer. A nonzero value takes the pin away from GPIO drive by forcing its output enable low. Pin inputs are asynchronous and are resynchronised inside the block. The register port is a plain control interface: a request is taken in the cycle `bus_en` is high and is never stalled. Read data comes back one cycle later with `bus_rvalid`.

Top module: `gpio_bank`

## Requirements
- R1: After reset, the output latch, direction, edge enables, edge status and alternate-function fields are all zero. So `pin_out`, `pin_oe`, `pin_af`, `irq` and `bus_rvalid` are all low.
- R2: With NW = NPINS/32, register words are addressed by word index. The group order is: level (0), direction (1), set (2), clear (3), rising enable (4), falling enable (5), edge status (6). Pin p sits in word group*NW + p/32 at bit p%32. The alternate-function words follow at 7*NW + p/16, with pin p's field at bits (p%16)*2+1:(p%16)*2.
- R3: A read of a level word returns pin levels delayed by a two-flop synchroniser. Writes to level words have no effect.
- R4: A direction bit of 1 makes the pin an output (`pin_oe` high, unless R10 applies). A 0 makes it an input.
- R5: Writing 1 to a bit of a set word drives that latch bit high, and writing 1 to a bit of a clear word drives it low. Zero bits change nothing. Reading either word returns the output latch. `pin_out` shows the latch.
- R6: A rising edge of the synchronised level is detected when the pin's rising enable is 1, and a falling edge when its falling enable is 1. With both enabled, either edge is detected. With neither enabled, no status bit is set.
- R7: A detected edge sets the pin's status bit, which stays set until software writes 1 to it. Writing 0 leaves it unchanged.
- R8: If an edge is detected in the same cycle that software writes 1 to clear that status bit, the bit stays set.
- R9: `irq` is high exactly when at least one status bit is set.
- R10: A nonzero alternate-function field forces the pin's `pin_oe` low. Zero leaves GPIO control. The fields are readable and appear on `pin_af` (pin p at bits 2p+1:2p).
- R11: Reads of word addresses at or above 9*NW return zero, and writes to them change nothing.
- R12: A read request raises `bus_rvalid` with the data on the next cycle. `bus_rvalid` is low otherwise, and `bus_rdata` is zero when `bus_rvalid` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en | input | 1 | Register access request this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rvalid | output | 1 | Read data valid (one cycle after a read request) |
| bus_rdata | output | 32 | Read data |
| pin_in | input | NPINS | Asynchronous pin input levels |
| pin_out | output | NPINS | Output latch values |
| pin_oe | output | NPINS | Output enables |
| pin_af | output | 2*NPINS | Alternate-function selectors, 2 bits per pin |
| irq | output | 1 | Combined edge interrupt |

## Verification
Two events can meet in one cycle: an edge detected on a pin, and a software write-one-to-clear of that same pin's status bit. The bench provokes this by toggling an enabled pin and then issuing the clear after a delay. It sweeps that delay over several cycles around the known synchroniser latency, so that one pass lands the write exactly in the detection cycle. A behavioural model, updated every clock, judges each pass by expecting the bit to survive that collision. The model is compared with `irq` every cycle and with the status word when it is read back.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int WORD_W = 32;
  typedef enum int {
    GRP_LEVEL = 0,
    GRP_DIR   = 1,
    GRP_SET   = 2,
    GRP_CLR   = 3,
    GRP_RISE  = 4,
    GRP_FALL  = 5,
    GRP_STAT  = 6
  } grp_e;
  localparam int NUM_BIT_GRPS = 7;
endpackage

// File: rtl/gpio_bank_sync.sv
module gpio_bank_sync #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_out
);
  logic [W-1:0] stage1_q;
  logic [W-1:0] stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= async_in;
      stage2_q <= stage1_q;
    end
  end

  assign sync_out = stage2_q;
endmodule

// File: rtl/gpio_bank_edge.sv
module gpio_bank_edge #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl,
  input  logic [W-1:0] rise_en,
  input  logic [W-1:0] fall_en,
  input  logic [W-1:0] clr,
  output logic [W-1:0] sts
);
  logic [W-1:0] prev_q;
  logic [W-1:0] ev;

  assign ev = (lvl & ~prev_q & rise_en) | (~lvl & prev_q & fall_en);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      sts    <= '0;
    end else begin
      prev_q <= lvl;
      sts    <= (sts & ~clr) | ev;
    end
  end

  // R8: a detection always lands, even against a clear
  a_r8_edge_not_lost: assert property (@(posedge clk) disable iff (!rst_n)
    (ev != '0) |=> ((sts & $past(ev)) == $past(ev)));

  // R7: a cleared bit with no new edge drops
  a_r7_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (clr != '0) |=> ((sts & $past(clr & ~ev)) == '0));

  // R7: uncleared bits hold
  a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (sts != '0) |=> ((sts & $past(sts & ~clr)) == $past(sts & ~clr)));

  // R6: with no enables no bit can rise
  a_r6_quiet_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_en == '0 && fall_en == '0) |=> ((sts & ~$past(sts)) == '0));
endmodule

// File: rtl/gpio_bank_dec.sv
module gpio_bank_dec #(
  parameter int NW     = 2,
  parameter int ADDR_W = 8,
  localparam int NBIT_WORDS = 7 * NW,
  localparam int NAF_WORDS  = 2 * NW
) (
  input  logic                  en,
  input  logic [ADDR_W-1:0]     addr,
  output logic [NBIT_WORDS-1:0] bit_hit,
  output logic [NAF_WORDS-1:0]  af_hit
);
  for (genvar i = 0; i < NBIT_WORDS; i++) begin : g_bit
    assign bit_hit[i] = en && (addr == ADDR_W'(i));
  end
  for (genvar j = 0; j < NAF_WORDS; j++) begin : g_af
    assign af_hit[j] = en && (addr == ADDR_W'(NBIT_WORDS + j));
  end
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_bank_pkg::*;
#(
  parameter int NPINS  = 64,
  parameter int ADDR_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_en,
  input  logic                 bus_we,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [31:0]          bus_wdata,
  output logic                 bus_rvalid,
  output logic [31:0]          bus_rdata,
  input  logic [NPINS-1:0]     pin_in,
  output logic [NPINS-1:0]     pin_out,
  output logic [NPINS-1:0]     pin_oe,
  output logic [2*NPINS-1:0]   pin_af,
  output logic                 irq
);
  localparam int NW         = NPINS / WORD_W;
  localparam int NBIT_WORDS = NUM_BIT_GRPS * NW;
  localparam int NAF_WORDS  = 2 * NW;
  localparam int NMAP       = NBIT_WORDS + NAF_WORDS;

  logic [NPINS-1:0]      lvl, dir_q, out_q, rise_q, fall_q, sts, clr_vec;
  logic [2*NPINS-1:0]    af_q;
  logic [NBIT_WORDS-1:0] bit_hit;
  logic [NAF_WORDS-1:0]  af_hit;
  logic [NPINS-1:0]      grp_val [NUM_BIT_GRPS];
  logic [31:0]           rd_mux;
  logic                  wr_go;

  gpio_bank_sync #(.W(NPINS)) sync_i (
    .clk(clk), .rst_n(rst_n), .async_in(pin_in), .sync_out(lvl));

  gpio_bank_dec #(.NW(NW), .ADDR_W(ADDR_W)) dec_i (
    .en(bus_en), .addr(bus_addr), .bit_hit(bit_hit), .af_hit(af_hit));

  gpio_bank_edge #(.W(NPINS)) edge_i (
    .clk(clk), .rst_n(rst_n), .lvl(lvl), .rise_en(rise_q),
    .fall_en(fall_q), .clr(clr_vec), .sts(sts));

  assign wr_go = bus_en && bus_we;

  always_comb begin
    clr_vec = '0;
    for (int w = 0; w < NW; w++) begin
      if (wr_go && bit_hit[GRP_STAT*NW + w]) clr_vec[w*32 +: 32] = bus_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q  <= '0;
      out_q  <= '0;
      rise_q <= '0;
      fall_q <= '0;
      af_q   <= '0;
    end else if (wr_go) begin
      for (int w = 0; w < NW; w++) begin
        if (bit_hit[GRP_DIR*NW + w])  dir_q[w*32 +: 32]  <= bus_wdata;
        if (bit_hit[GRP_SET*NW + w])  out_q[w*32 +: 32]  <= out_q[w*32 +: 32] | bus_wdata;
        if (bit_hit[GRP_CLR*NW + w])  out_q[w*32 +: 32]  <= out_q[w*32 +: 32] & ~bus_wdata;
        if (bit_hit[GRP_RISE*NW + w]) rise_q[w*32 +: 32] <= bus_wdata;
        if (bit_hit[GRP_FALL*NW + w]) fall_q[w*32 +: 32] <= bus_wdata;
      end
      for (int j = 0; j < NAF_WORDS; j++) begin
        if (af_hit[j]) af_q[j*32 +: 32] <= bus_wdata;
      end
    end
  end

  assign grp_val[GRP_LEVEL] = lvl;
  assign grp_val[GRP_DIR]   = dir_q;
  assign grp_val[GRP_SET]   = out_q;
  assign grp_val[GRP_CLR]   = out_q;
  assign grp_val[GRP_RISE]  = rise_q;
  assign grp_val[GRP_FALL]  = fall_q;
  assign grp_val[GRP_STAT]  = sts;

  always_comb begin
    rd_mux = '0;
    for (int g = 0; g < NUM_BIT_GRPS; g++) begin
      for (int w = 0; w < NW; w++) begin
        if (bit_hit[g*NW + w]) rd_mux = grp_val[g][w*32 +: 32];
      end
    end
    for (int j = 0; j < NAF_WORDS; j++) begin
      if (af_hit[j]) rd_mux = af_q[j*32 +: 32];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rvalid <= 1'b0;
      bus_rdata  <= '0;
    end else begin
      bus_rvalid <= bus_en && !bus_we;
      bus_rdata  <= (bus_en && !bus_we) ? rd_mux : '0;
    end
  end

  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    assign pin_oe[p] = dir_q[p] && (af_q[2*p +: 2] == 2'b00);
  end

  assign pin_out = out_q;
  assign pin_af  = af_q;
  assign irq     = |sts;

  // R5: write-one-to-set on the first set word
  a_r5_set_word0: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_go && bus_addr == ADDR_W'(GRP_SET*NW))
      |=> ((pin_out[31:0] & $past(bus_wdata)) == $past(bus_wdata)));

  // R5: write-one-to-clear on the first clear word
  a_r5_clr_word0: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_go && bus_addr == ADDR_W'(GRP_CLR*NW))
      |=> ((pin_out[31:0] & $past(bus_wdata)) == '0));

  // R11: unmapped reads return zero
  a_r11_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && !bus_we && int'(bus_addr) >= NMAP) |=> (bus_rdata == '0));
endmodule

// File: tb/gpio_bank_tb.sv
module gpio_bank_tb_top;
  localparam int  NPINS  = 64;
  localparam int  ADDR_W = 8;
  localparam int  NW     = NPINS / 32;
  localparam int  NMAP   = 9 * NW;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_en = 1'b0, bus_we = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic bus_rvalid;
  logic [31:0] bus_rdata;
  logic [NPINS-1:0] pin_in = '0;
  logic [NPINS-1:0] pin_out, pin_oe;
  logic [2*NPINS-1:0] pin_af;
  logic irq;

  int checks = 0;
  int errors = 0;
  bit live = 1'b0;
  string tag = "R1";

  // behavioural model state
  logic [NPINS-1:0] m_s1, m_s2, m_prev, m_dir, m_out, m_ren, m_fen, m_sts;
  logic [2*NPINS-1:0] m_af;
  logic m_rvalid;
  logic [31:0] m_rdata;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_bank #(.NPINS(NPINS), .ADDR_W(ADDR_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rvalid(bus_rvalid),
    .bus_rdata(bus_rdata), .pin_in(pin_in), .pin_out(pin_out),
    .pin_oe(pin_oe), .pin_af(pin_af), .irq(irq));

  function automatic logic [31:0] m_read(int a);
    int g, w;
    logic [NPINS-1:0] v;
    if (a < 7*NW) begin
      g = a / NW; w = a % NW;
      case (g)
        0: v = m_s2;
        1: v = m_dir;
        2, 3: v = m_out;
        4: v = m_ren;
        5: v = m_fen;
        default: v = m_sts;
      endcase
      return v[w*32 +: 32];
    end else if (a < NMAP) begin
      return m_af[(a-7*NW)*32 +: 32];
    end
    return 32'h0;
  endfunction

  always @(posedge clk) begin
    logic [NPINS-1:0] ev, clrv;
    int a, w;
    if (!rst_n) begin
      m_s1 = '0; m_s2 = '0; m_prev = '0; m_dir = '0; m_out = '0;
      m_ren = '0; m_fen = '0; m_sts = '0; m_af = '0;
      m_rvalid = 1'b0; m_rdata = '0;
    end else begin
      ev = (m_s2 & ~m_prev & m_ren) | (~m_s2 & m_prev & m_fen);
      clrv = '0;
      a = int'(bus_addr);
      m_rvalid = bus_en && !bus_we;
      m_rdata = (bus_en && !bus_we) ? m_read(a) : 32'h0;
      if (bus_en && bus_we) begin
        if (a < 7*NW) begin
          w = a % NW;
          case (a / NW)
            1: m_dir[w*32 +: 32] = bus_wdata;
            2: m_out[w*32 +: 32] = m_out[w*32 +: 32] | bus_wdata;
            3: m_out[w*32 +: 32] = m_out[w*32 +: 32] & ~bus_wdata;
            4: m_ren[w*32 +: 32] = bus_wdata;
            5: m_fen[w*32 +: 32] = bus_wdata;
            6: clrv[w*32 +: 32] = bus_wdata;
            default: ;
          endcase
        end else if (a < NMAP) begin
          m_af[(a-7*NW)*32 +: 32] = bus_wdata;
        end
      end
      m_sts  = (m_sts & ~clrv) | ev;
      m_prev = m_s2;
      m_s2   = m_s1;
      m_s1   = pin_in;
    end
  end

  task automatic chk(string t, string what, logic [2*NPINS-1:0] act, logic [2*NPINS-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", t, what, act, exp);
    end
  endtask

  task automatic compare();
    logic [NPINS-1:0] oe_exp;
    for (int p = 0; p < NPINS; p++) oe_exp[p] = m_dir[p] && (m_af[2*p +: 2] == 2'b00);
    chk("R5", "pin_out", pin_out, m_out);
    chk((tag == "R10") ? "R10" : "R4", "pin_oe", pin_oe, oe_exp);
    chk("R10", "pin_af", pin_af, m_af);
    chk("R9", "irq", irq, |m_sts);
    chk("R12", "bus_rvalid", bus_rvalid, m_rvalid);
    chk(tag, "bus_rdata", bus_rdata, m_rdata);
  endtask

  task automatic cyc();
    @(negedge clk);
    if (live) compare();
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  task automatic wr(int a, logic [31:0] d);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = ADDR_W'(a); bus_wdata = d;
    cyc();
    bus_en = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(int a);
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = ADDR_W'(a);
    cyc();
    bus_en = 1'b0;
    cyc();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state at the ports
    chk("R1", "pin_out", pin_out, '0);
    chk("R1", "pin_oe", pin_oe, '0);
    chk("R1", "pin_af", pin_af, '0);
    chk("R1", "irq", irq, '0);
    chk("R1", "bus_rvalid", bus_rvalid, '0);
    live = 1'b1;
    tag = "R1";
    for (int a = 0; a < NMAP; a++) rd(a);

    // R4 / R5: direction and set/clear latch
    tag = "R5";
    wr(1*NW + 0, 32'h0000_FFFF);
    wr(2*NW + 0, 32'h0000_00A5);
    wr(3*NW + 0, 32'h0000_0005);
    wr(2*NW + 0, 32'h0000_0000);
    wr(3*NW + 0, 32'h0000_0000);
    rd(2*NW + 0);
    rd(3*NW + 0);
    // R2: second word of each group maps to pins 32..63
    tag = "R2";
    wr(1*NW + 1, 32'h8000_0001);
    wr(2*NW + 1, 32'hFFFF_0000);
    wr(3*NW + 1, 32'h0F00_0000);
    rd(2*NW + 1);
    rd(1*NW + 1);

    // R3: synchronised level, writes to level ignored
    tag = "R3";
    pin_in = 64'hDEAD_BEEF_1234_5678;
    cyc();
    rd(0); rd(1);
    idle(2);
    rd(0); rd(1);
    wr(0, 32'hFFFF_FFFF);
    wr(1, 32'h0000_0000);
    rd(0); rd(1);

    // R6 / R7: edge enables, sticky status, write-one-to-clear
    tag = "R6";
    wr(4*NW + 0, 32'h0000_000F);
    wr(5*NW + 0, 32'h0000_00F0);
    wr(4*NW + 1, 32'h0000_0003);
    wr(5*NW + 1, 32'h0000_0003);
    pin_in = '0;
    idle(4);
    rd(6*NW + 0); rd(6*NW + 1);
    pin_in = 64'h0000_0003_0000_00FF;
    idle(4);
    rd(6*NW + 0); rd(6*NW + 1);
    pin_in = 64'h0000_0001_0000_0000;
    idle(4);
    rd(6*NW + 1);
    tag = "R7";
    wr(6*NW + 0, 32'h0000_0000);
    rd(6*NW + 0);
    wr(6*NW + 0, 32'h0000_0003);
    rd(6*NW + 0);
    wr(6*NW + 0, 32'hFFFF_FFFF);
    wr(6*NW + 1, 32'hFFFF_FFFF);
    idle(2);
    rd(6*NW + 0); rd(6*NW + 1);

    // R8: clear coinciding with a new edge, swept across the detect cycle
    tag = "R8";
    wr(4*NW + 0, 32'h0);
    wr(5*NW + 0, 32'h0);
    wr(4*NW + 1, 32'h0000_0100);
    wr(5*NW + 1, 32'h0);
    for (int off = 0; off < 5; off++) begin
      pin_in = '0;
      idle(4);
      wr(6*NW + 1, 32'hFFFF_FFFF);
      idle(1);
      pin_in[40] = 1'b1;
      idle(off);
      wr(6*NW + 1, 32'h0000_0100);
      idle(3);
      rd(6*NW + 1);
    end
    wr(6*NW + 1, 32'hFFFF_FFFF);
    wr(4*NW + 1, 32'h0);

    // R10: alternate function releases the pin
    tag = "R10";
    wr(1*NW + 0, 32'hFFFF_FFFF);
    wr(7*NW + 0, 32'h0000_0001);
    wr(7*NW + 1, 32'h0000_000C);
    wr(7*NW + 3, 32'hC000_0000);
    rd(7*NW + 0); rd(7*NW + 1); rd(7*NW + 3);
    wr(7*NW + 0, 32'h0);

    // R11: unmapped addresses
    tag = "R11";
    wr(NMAP, 32'hFFFF_FFFF);
    wr(255, 32'hFFFF_FFFF);
    rd(NMAP); rd(255);
    for (int a = 0; a < NMAP; a++) rd(a);

    // R2: mixed traffic against the model
    tag = "R2";
    for (int i = 0; i < 400; i++) begin
      bus_en    = ($urandom % 3) != 0;
      bus_we    = $urandom % 2;
      bus_addr  = ADDR_W'($urandom % (NMAP + 2));
      bus_wdata = $urandom;
      if ($urandom % 4 == 0) pin_in = {$urandom, $urandom};
      cyc();
    end
    bus_en = 1'b0;
    for (int a = 0; a < NMAP; a++) rd(a);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule